// File: doc/BRIEF.md
# Supervisory Down-Counting Watchdog with Sticky Reset Cause

This block checks that system software is still running. Software first stores a start value. It then turns the timer on. From that point a 32-bit counter decreases by one on every clock. Software must issue a reload before the counter runs out. A reload copies the stored start value back into the counter.

If the counter does run out, the block drives a system reset pulse of fixed length. The pulse goes to both the processor core and the on-chip peripherals. At the same moment the block turns the timer off and refills the counter from the stored start value. It also sets a cause flag. That flag is not cleared by the watchdog's own reset pulse. After the reset, software can read the flag to find out whether the watchdog caused it.

Software reaches the block through one register port. Writes take effect on a single clock edge. Reads are combinational from a separate read address. The block carries no data stream, so all pins are plain control and status signals with no valid/ready handshake and no back-pressure.

Register map:

| Address | Access | Content |
|---|---|---|
| 0 | read/write | Start value |
| 1 | read/write | Control. Bit 0 is enable. Bit 1 is the reload request. Bit 2 is the cause flag. |
| 2 | read-only | Live counter |
| 3 | read-only | Reads as zero |

Top module: `wdog_reset_unit`

## Requirements
- R1: After power-on reset (`por_n` low), the block is in its idle state:
  - `sys_rst_o` is 0.
  - The control register reads 0.
  - Both the start value (address 0) and the live counter (address 2) read as all ones.
- R2: A write to address 0 while the timer is disabled sets both the start value and the live counter. While the timer is enabled, such a write is ignored and the start value reads back unchanged.
- R3: While the timer is enabled, the live counter (address 2) drops by exactly one per clock. Once enable is written 0, the counter holds its value.
- R4: Suppose the start value is N ≥ 1 and the edge that writes control bit 0 = 1 is edge E. With no reload, `sys_rst_o` first reads 1 after edge E+N.
- R5: Once raised, `sys_rst_o` stays high for exactly PULSE_LEN clocks (16 by default), then returns low.
- R6: At expiry, the enable bit (control bit 0) is cleared and the live counter is refilled with the start value.
- R7: The cause flag (control bit 2) has these rules:
  - It is set at expiry.
  - The watchdog's own reset pulse does not clear it.
  - It clears only on power-on reset, or on a control write with bit 2 = 1.
- R8: A control write with bit 1 = 1 refills the live counter from the start value on that edge. Bit 1 always reads back as 0.
- R9: A reload on the same edge where the counter would expire takes priority. The counter is refilled and no reset pulse starts.
- R10: Every register write made while `sys_rst_o` is high is ignored, including writes to enable, the start value and the cause clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 2 | Write register address |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 2 | Read register address |
| bus_rdata | output | 32 | Combinational read data |
| sys_rst_o | output | 1 | Reset pulse to core and peripherals, active high |

## Verification
The bound checker watches several properties on every cycle:
- the exact pulse width;
- the one-per-clock countdown;
- enable being cleared and the counter refilled when a pulse starts;
- the cause flag staying set until a control write;
- locked start-value writes while enabled;
- reload winning over expiry;
- writes being frozen during a pulse.

Only the bench's scenarios can show the full count-to-reset latency for each start value, read back through the bus. The same holds for three other behaviours: a stream of timely reloads keeping the system free of resets, the cause flag surviving the pulse but not a clear write, and power-on reset wiping the flag.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_START = 2'd0,
    REG_CTRL  = 2'd1,
    REG_LIVE  = 2'd2,
    REG_NONE  = 2'd3
  } wdog_reg_e;

  localparam int unsigned CTRL_EN_BIT     = 0;
  localparam int unsigned CTRL_RELOAD_BIT = 1;
  localparam int unsigned CTRL_CAUSE_BIT  = 2;
  localparam int unsigned CTRL_BITS       = 3;

  typedef struct packed {
    logic cause_clr;
    logic reload;
    logic enable;
  } ctrl_wr_t;
endpackage

// File: rtl/wdog_regfile.sv
`timescale 1ns/1ps
module wdog_regfile #(
  parameter int unsigned CNT_W      = 32,
  parameter logic [CNT_W-1:0] INIT_COUNT = '1
) (
  input  logic                      clk,
  input  logic                      por_n,
  input  logic                      bus_wr,
  input  logic [wdog_pkg::ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]          bus_wdata,
  input  logic                      expire,
  input  logic                      rst_active,
  output logic [CNT_W-1:0]          start_val,
  output logic                      wd_enable,
  output logic                      wd_cause,
  output logic                      reload_req,
  output logic                      load_live
);
  import wdog_pkg::*;

  logic     wr_ok;
  logic     wr_start;
  logic     wr_ctrl;
  ctrl_wr_t ctrl_w;

  // Writes are frozen while the reset pulse is active.
  assign wr_ok    = bus_wr && !rst_active;
  assign wr_start = wr_ok && (bus_addr == REG_START);
  assign wr_ctrl  = wr_ok && (bus_addr == REG_CTRL);

  assign ctrl_w.enable    = bus_wdata[CTRL_EN_BIT];
  assign ctrl_w.reload    = bus_wdata[CTRL_RELOAD_BIT];
  assign ctrl_w.cause_clr = bus_wdata[CTRL_CAUSE_BIT];

  // Start value may only change while the timer is stopped.
  assign load_live  = wr_start && !wd_enable;
  assign reload_req = wr_ctrl && ctrl_w.reload;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      start_val <= INIT_COUNT;
    end else if (load_live) begin
      start_val <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wd_enable <= 1'b0;
    end else if (expire) begin
      wd_enable <= 1'b0;
    end else if (wr_ctrl) begin
      wd_enable <= ctrl_w.enable;
    end
  end

  // Cause flag: set by expiry, cleared by write-one or power-on only.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wd_cause <= 1'b0;
    end else if (expire) begin
      wd_cause <= 1'b1;
    end else if (wr_ctrl && ctrl_w.cause_clr) begin
      wd_cause <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_downcounter.sv
`timescale 1ns/1ps
module wdog_downcounter #(
  parameter int unsigned CNT_W      = 32,
  parameter logic [CNT_W-1:0] INIT_COUNT = '1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             wd_enable,
  input  logic             reload_req,
  input  logic             load_live,
  input  logic [CNT_W-1:0] new_val,
  input  logic [CNT_W-1:0] start_val,
  output logic [CNT_W-1:0] live_cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_end;

  // The step from one to zero is the expiry; a zero start behaves as one.
  assign at_end = (live_cnt <= ONE);
  assign expire = wd_enable && at_end && !reload_req;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      live_cnt <= INIT_COUNT;
    end else if (load_live) begin
      live_cnt <= new_val;
    end else if (reload_req || expire) begin
      live_cnt <= start_val;
    end else if (wd_enable) begin
      live_cnt <= live_cnt - ONE;
    end
  end
endmodule

// File: rtl/wdog_pulse_gen.sv
`timescale 1ns/1ps
module wdog_pulse_gen #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic expire,
  output logic rst_out
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] remain;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_out <= 1'b0;
      remain  <= '0;
    end else if (expire) begin
      rst_out <= 1'b1;
      remain  <= PW'(PULSE_LEN - 1);
    end else if (remain != '0) begin
      remain  <= remain - PW'(1);
    end else begin
      rst_out <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_reset_unit.sv
`timescale 1ns/1ps
module wdog_reset_unit #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned PULSE_LEN  = 16,
  parameter logic [CNT_W-1:0] INIT_COUNT = '1
) (
  input  logic                        clk,
  input  logic                        por_n,
  input  logic                        bus_wr,
  input  logic [wdog_pkg::ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]            bus_wdata,
  input  logic [wdog_pkg::ADDR_W-1:0] bus_raddr,
  output logic [CNT_W-1:0]            bus_rdata,
  output logic                        sys_rst_o
);
  import wdog_pkg::*;

  logic [CNT_W-1:0] start_val;
  logic [CNT_W-1:0] live_cnt;
  logic             wd_enable;
  logic             wd_cause;
  logic             reload_req;
  logic             load_live;
  logic             expire;

  wdog_regfile #(.CNT_W(CNT_W), .INIT_COUNT(INIT_COUNT)) u_regs (
    .clk        (clk),
    .por_n      (por_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .expire     (expire),
    .rst_active (sys_rst_o),
    .start_val  (start_val),
    .wd_enable  (wd_enable),
    .wd_cause   (wd_cause),
    .reload_req (reload_req),
    .load_live  (load_live)
  );

  wdog_downcounter #(.CNT_W(CNT_W), .INIT_COUNT(INIT_COUNT)) u_cnt (
    .clk        (clk),
    .por_n      (por_n),
    .wd_enable  (wd_enable),
    .reload_req (reload_req),
    .load_live  (load_live),
    .new_val    (bus_wdata),
    .start_val  (start_val),
    .live_cnt   (live_cnt),
    .expire     (expire)
  );

  wdog_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk     (clk),
    .por_n   (por_n),
    .expire  (expire),
    .rst_out (sys_rst_o)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_raddr)
      REG_START: bus_rdata = start_val;
      REG_CTRL: begin
        bus_rdata[CTRL_EN_BIT]    = wd_enable;
        bus_rdata[CTRL_CAUSE_BIT] = wd_cause;
      end
      REG_LIVE:  bus_rdata = live_cnt;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_reset_unit_chk.sv
`timescale 1ns/1ps
module wdog_reset_unit_chk #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned PULSE_LEN = 16
) (
  input logic                        clk,
  input logic                        por_n,
  input logic                        rst_o,
  input logic                        en,
  input logic                        cause,
  input logic [CNT_W-1:0]            cnt,
  input logic [CNT_W-1:0]            start,
  input logic                        reload,
  input logic                        wr,
  input logic [wdog_pkg::ADDR_W-1:0] addr
);
  import wdog_pkg::*;

  localparam int unsigned HW = $clog2(PULSE_LEN + 1) + 1;

  logic [HW-1:0] hi_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hi_run <= '0;
    end else if (rst_o) begin
      hi_run <= hi_run + HW'(1);
    end else begin
      hi_run <= '0;
    end
  end

  assert_pulse_cap_R5: assert property (@(posedge clk) disable iff (!por_n)
    rst_o |-> (hi_run < HW'(PULSE_LEN)));

  assert_pulse_full_R5: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_o) |-> (hi_run == HW'(PULSE_LEN)));

  assert_countdown_R3: assert property (@(posedge clk) disable iff (!por_n)
    (en && !reload && cnt > CNT_W'(1) && !(wr && addr == REG_START))
      |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_expiry_state_R6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_o) |-> (!en && cnt == start));

  assert_cause_set_R7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_o) |-> cause);

  assert_cause_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
    (cause && !(wr && addr == REG_CTRL)) |=> cause);

  assert_start_locked_R2: assert property (@(posedge clk) disable iff (!por_n)
    (en && wr && addr == REG_START) |=> $stable(start));

  assert_reload_wins_R9: assert property (@(posedge clk) disable iff (!por_n)
    (en && reload && cnt <= CNT_W'(1)) |=> !$rose(rst_o));

  assert_frozen_writes_R10: assert property (@(posedge clk) disable iff (!por_n)
    (rst_o && wr) |=> ($stable(start) && $stable(en)));
endmodule

bind wdog_reset_unit wdog_reset_unit_chk #(
  .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk    (clk),
  .por_n  (por_n),
  .rst_o  (sys_rst_o),
  .en     (wd_enable),
  .cause  (wd_cause),
  .cnt    (live_cnt),
  .start  (start_val),
  .reload (reload_req),
  .wr     (bus_wr),
  .addr   (bus_addr)
);

// File: tb/wdog_reset_unit_bench.sv
`timescale 1ns/1ps
module wdog_reset_unit_bench;
  localparam int unsigned CNT_W = 32;
  localparam int unsigned PLEN  = 16;
  localparam logic [31:0] ONES  = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_raddr = '0;
  logic [31:0] bus_rdata;
  logic        sys_rst_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_reset_unit #(.CNT_W(CNT_W), .PULSE_LEN(PLEN)) u_wdog_reset_unit (
    .clk(clk), .por_n(por_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .sys_rst_o(sys_rst_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      failures = failures + 1;
      $display("FAIL watchdog expired act=%0d exp=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    bus_raddr = a;
    #0.1;
    v = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    int k;
    int h;
    bit bad;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    chk("R1 rst idle", {31'd0, sys_rst_o}, 32'd0);
    rd(2'd1, v); chk("R1 ctrl", v, 32'd0);
    rd(2'd0, v); chk("R1 start", v, ONES);
    rd(2'd2, v); chk("R1 live", v, ONES);

    // Sweep start values: latency, pulse width, post-expiry state.
    for (int n = 1; n <= 12; n++) begin
      wr(2'd0, n);
      rd(2'd2, v); chk("R2 live load", v, n);
      wr(2'd1, 32'd1);
      k = 0;
      while (!sys_rst_o && k < n + 5) begin
        @(negedge clk);
        k++;
      end
      chk("R4 latency", k, n);
      h = 1;
      @(negedge clk);
      while (sys_rst_o && h < 40) begin
        h++;
        @(negedge clk);
      end
      chk("R5 pulse width", h, PLEN);
      rd(2'd1, v); chk("R6 R7 ctrl after expiry", v, 32'd4);
      rd(2'd2, v); chk("R6 live refilled", v, n);
      wr(2'd1, 32'd4);
      rd(2'd1, v); chk("R7 cause cleared", v, 32'd0);
    end

    // Countdown and hold.
    wr(2'd0, 32'd100);
    wr(2'd1, 32'd1);
    repeat (7) @(negedge clk);
    rd(2'd2, v); chk("R3 countdown", v, 32'd93);
    wr(2'd1, 32'd0);
    repeat (3) @(negedge clk);
    rd(2'd2, v); chk("R3 hold when off", v, 32'd92);

    // Start value locked while enabled.
    wr(2'd1, 32'd1);
    wr(2'd0, 32'd500);
    rd(2'd0, v); chk("R2 locked start", v, 32'd100);
    wr(2'd1, 32'd0);

    // Reload refills and keeps resets away.
    wr(2'd0, 32'd20);
    wr(2'd1, 32'd1);
    repeat (5) @(negedge clk);
    wr(2'd1, 32'd3);
    rd(2'd2, v); chk("R8 reload value", v, 32'd20);
    rd(2'd1, v); chk("R8 reload bit reads 0", v, 32'd1);
    bad = 1'b0;
    for (int i = 0; i < 10; i++) begin
      repeat (9) begin
        @(negedge clk);
        if (sys_rst_o) bad = 1'b1;
      end
      wr(2'd1, 32'd3);
    end
    chk("R8 no reset under reloads", {31'd0, bad}, 32'd0);
    wr(2'd1, 32'd0);

    // Reload on the expiry edge wins.
    wr(2'd0, 32'd4);
    wr(2'd1, 32'd1);
    repeat (3) @(negedge clk);
    wr(2'd1, 32'd3);
    chk("R9 no pulse", {31'd0, sys_rst_o}, 32'd0);
    rd(2'd2, v); chk("R9 refilled", v, 32'd4);
    @(negedge clk);
    chk("R9 still no pulse", {31'd0, sys_rst_o}, 32'd0);
    wr(2'd1, 32'd0);
    rd(2'd1, v); chk("R9 cause clear", v, 32'd0);

    // Writes during the pulse are ignored.
    wr(2'd0, 32'd2);
    wr(2'd1, 32'd1);
    k = 0;
    while (!sys_rst_o && k < 10) begin
      @(negedge clk);
      k++;
    end
    wr(2'd0, 32'd55);
    wr(2'd1, 32'd1);
    wr(2'd1, 32'd4);
    k = 0;
    while (sys_rst_o && k < 40) begin
      @(negedge clk);
      k++;
    end
    rd(2'd0, v); chk("R10 start frozen", v, 32'd2);
    rd(2'd1, v); chk("R10 R7 ctrl frozen, cause kept", v, 32'd4);

    // Power-on reset clears the cause.
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    rd(2'd1, v); chk("R7 por clears cause", v, 32'd0);
    rd(2'd0, v); chk("R1 start after por", v, ONES);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule